// File: doc/BRIEF.md
# Shared Multi-Latency Arithmetic Unit

This block is one arithmetic resource shared by a sequential update stage. In any cycle the stage may hand it a single operation: add, subtract, multiply or divide, with two unsigned fixed-point operands and a destination address. The result comes back a fixed number of cycles later, tagged with that address and marked by a valid strobe, so that the stage can write it into its data RAM without keeping any record of its own.

Add, subtract and multiply share one latency of twelve cycles. The multiplier core is shorter than that and is padded with registers to line up with the adder. Divide is a pipelined restoring divider with a latency of twenty-seven cycles that is deliberately not matched to the others. Both result streams feed one write-back port. When a fast result and a divide result complete in the same cycle, the fast one is kept and a collision strobe is raised. A zero divisor yields an all-ones quotient and sets a sticky error flag. The unit never stalls, and a new operation may be issued in every cycle.

Top module: `shared_alu`

## Requirements
- R1: While reset is held and after it is released, before any result completes, resValid, collisionErr and divZeroErr are 0.
- R2: Operation code 0 adds and code 1 subtracts (opA minus opB), both modulo 2^DATA_W. An operation issued in cycle c appears in cycle c+12 with resValid 1 and resDest equal to its issueDest.
- R3: Operation code 2 returns the low DATA_W bits of opA times opB in cycle c+12, with its destination.
- R4: Operation code 3 returns the unsigned truncated quotient opA / opB in cycle c+27, with its destination.
- R5: An operation may be issued in every cycle without stall. Each completing result appears in its own completion cycle, so results leave in order of completion and not in order of issue.
- R6: When a code 0–2 result and a code 3 result complete in the same cycle, the ports carry the code 0–2 result, the divide result is dropped, and collisionErr is 1 for that cycle only. Otherwise collisionErr is 0.
- R7: A divide with opB equal to 0 returns an all-ones quotient.
- R8: divZeroErr goes to 1 in the cycle a zero-divisor divide completes, even if that result is dropped by a collision, and it stays 1 until reset.
- R9: A cycle with issueValid 0 issues nothing. In a cycle where no issued operation completes, resValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| issueValid | input | 1 | An operation is presented this cycle |
| issueOp | input | 2 | 0 add, 1 subtract, 2 multiply, 3 divide |
| opA | input | DATA_W | First operand, or the dividend |
| opB | input | DATA_W | Second operand, or the divisor |
| issueDest | input | DEST_W | Write-back address carried with the operation |
| resValid | output | 1 | A result is present this cycle |
| resData | output | DATA_W | Result value |
| resDest | output | DEST_W | Write-back address of the result |
| collisionErr | output | 1 | A divide result was dropped this cycle |
| divZeroErr | output | 1 | Sticky: a zero-divisor divide has completed |

## Verification
The hardest case to reach from the ports is a collision, which needs a divide issued exactly fifteen cycles before a fast operation. A directed sequence places one such pair, and one that carries a zero divisor, so that the sticky flag is seen to be set by a dropped result. After that, a long seeded random run issues in most cycles with all four operations mixed, which produces many chance alignments of the two streams. Divisors in that run are sometimes small and sometimes zero, so that both non-trivial quotients and the saturated case occur.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2,
    OP_DIV = 2'd3
  } opKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic subSel;    // issue-time: subtract instead of add
    logic pickFast;  // tail-time: fast stream owns the port
    logic pickMul;   // tail-time: fast result is a product
    logic pickSlow;  // tail-time: divide stream owns the port
    logic slowDone;  // tail-time: a divide completes (kept or not)
  } dpStrobe_t;

endpackage

// File: rtl/alu_delay_line.sv
module alu_delay_line #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic [WIDTH-1:0] q;
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= '0;
        else       q <= dIn;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= '0;
        else       q <= g_stage[i-1].q;
      end
    end
  end

  assign dOut = g_stage[DEPTH-1].q;

endmodule

// File: rtl/alu_divider_pipe.sv
module alu_divider_pipe #(
  parameter int DATA_W = 16,
  parameter int DIV_LAT = 27
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dividend,
  input  logic [DATA_W-1:0] divisor,
  output logic [DATA_W-1:0] quotTail,
  output logic              zeroTail
);

  localparam int STEPS = DATA_W;
  localparam int PAD   = DIV_LAT - 1 - STEPS;

  logic [DATA_W-1:0] remQ [STEPS];
  logic [DATA_W-1:0] quoQ [STEPS];
  logic [DATA_W-1:0] dsrQ [STEPS];
  logic              dzQ  [STEPS];

  logic [DATA_W-1:0] remNx [STEPS];
  logic [DATA_W-1:0] quoNx [STEPS];

  // one restoring step per stage
  always_comb begin
    for (int s = 0; s < STEPS; s++) begin
      logic [DATA_W-1:0] remIn;
      logic [DATA_W-1:0] quoIn;
      logic [DATA_W-1:0] dsrIn;
      logic [DATA_W:0]   trial;
      logic              take;
      remIn = (s == 0) ? '0 : remQ[(s == 0) ? 0 : s-1];
      quoIn = (s == 0) ? dividend : quoQ[(s == 0) ? 0 : s-1];
      dsrIn = (s == 0) ? divisor : dsrQ[(s == 0) ? 0 : s-1];
      trial = {remIn, quoIn[DATA_W-1]};
      take  = trial >= {1'b0, dsrIn};
      remNx[s] = take ? (trial[DATA_W-1:0] - dsrIn) : trial[DATA_W-1:0];
      quoNx[s] = {quoIn[DATA_W-2:0], take};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STEPS; s++) begin
        remQ[s] <= '0;
        quoQ[s] <= '0;
        dsrQ[s] <= '0;
        dzQ[s]  <= 1'b0;
      end
    end else begin
      for (int s = 0; s < STEPS; s++) begin
        remQ[s] <= remNx[s];
        quoQ[s] <= quoNx[s];
        dsrQ[s] <= (s == 0) ? divisor : dsrQ[(s == 0) ? 0 : s-1];
        dzQ[s]  <= (s == 0) ? (divisor == '0) : dzQ[(s == 0) ? 0 : s-1];
      end
    end
  end

  // pad the divide stream up to its own fixed latency
  logic [DATA_W:0] padOut;

  alu_delay_line #(.WIDTH(DATA_W + 1), .DEPTH(PAD)) u_pad (
    .clk (clk),
    .rstN(rstN),
    .dIn ({quoQ[STEPS-1], dzQ[STEPS-1]}),
    .dOut(padOut)
  );

  assign quotTail = padOut[DATA_W:1];
  assign zeroTail = padOut[0];

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADD_LAT = 12,
  parameter int MUL_CORE_LAT = 5,
  parameter int DIV_LAT = 27
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  dpStrobe_t         st,
  output logic [DATA_W-1:0] resData,
  output logic              divZeroErr
);

  localparam int FAST_DEPTH = ADD_LAT - 1;
  localparam int MUL_PAD    = ADD_LAT - MUL_CORE_LAT;

  // add/subtract path
  logic [DATA_W-1:0] addIn;
  logic [DATA_W-1:0] addTail;
  assign addIn = st.subSel ? (opA - opB) : (opA + opB);

  alu_delay_line #(.WIDTH(DATA_W), .DEPTH(FAST_DEPTH)) u_addPipe (
    .clk(clk), .rstN(rstN), .dIn(addIn), .dOut(addTail)
  );

  // multiply path: core stages, then padding to the adder latency
  logic [DATA_W-1:0] mulIn;
  logic [DATA_W-1:0] mulCore;
  logic [DATA_W-1:0] mulTail;
  assign mulIn = DATA_W'(opA * opB);

  alu_delay_line #(.WIDTH(DATA_W), .DEPTH(MUL_CORE_LAT - 1)) u_mulCore (
    .clk(clk), .rstN(rstN), .dIn(mulIn), .dOut(mulCore)
  );

  alu_delay_line #(.WIDTH(DATA_W), .DEPTH(MUL_PAD)) u_mulPad (
    .clk(clk), .rstN(rstN), .dIn(mulCore), .dOut(mulTail)
  );

  // divide path, unmatched latency
  logic [DATA_W-1:0] divTail;
  logic              dzTail;

  alu_divider_pipe #(.DATA_W(DATA_W), .DIV_LAT(DIV_LAT)) u_div (
    .clk     (clk),
    .rstN    (rstN),
    .dividend(opA),
    .divisor (opB),
    .quotTail(divTail),
    .zeroTail(dzTail)
  );

  // write-back merge register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resData    <= '0;
      divZeroErr <= 1'b0;
    end else begin
      if (st.pickFast)      resData <= st.pickMul ? mulTail : addTail;
      else if (st.pickSlow) resData <= divTail;
      if (st.slowDone && dzTail) divZeroErr <= 1'b1;
    end
  end

endmodule

// File: rtl/alu_control.sv
module alu_control
  import alu_pkg::*;
#(
  parameter int DEST_W = 6,
  parameter int ADD_LAT = 12,
  parameter int DIV_LAT = 27
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [1:0]        issueOp,
  input  logic [DEST_W-1:0] issueDest,
  output dpStrobe_t         st,
  output logic              resValid,
  output logic [DEST_W-1:0] resDest,
  output logic              collisionErr
);

  localparam int FAST_W = DEST_W + 2;
  localparam int SLOW_W = DEST_W + 1;

  opKind_e op;
  assign op = opKind_e'(issueOp);

  logic fastGo, divGo, isMul;
  assign fastGo = issueValid && (op != OP_DIV);
  assign divGo  = issueValid && (op == OP_DIV);
  assign isMul  = (op == OP_MUL);

  logic [FAST_W-1:0] fastTail;
  logic [SLOW_W-1:0] slowTail;

  alu_delay_line #(.WIDTH(FAST_W), .DEPTH(ADD_LAT - 1)) u_fastTag (
    .clk(clk), .rstN(rstN), .dIn({fastGo, isMul, issueDest}), .dOut(fastTail)
  );

  alu_delay_line #(.WIDTH(SLOW_W), .DEPTH(DIV_LAT - 1)) u_slowTag (
    .clk(clk), .rstN(rstN), .dIn({divGo, issueDest}), .dOut(slowTail)
  );

  logic              fastV, fastMul, slowV;
  logic [DEST_W-1:0] fastDest, slowDest;
  assign {fastV, fastMul, fastDest} = fastTail;
  assign {slowV, slowDest}          = slowTail;

  always_comb begin
    st.subSel   = (op == OP_SUB);
    st.pickFast = fastV;
    st.pickMul  = fastMul;
    st.pickSlow = slowV && !fastV;
    st.slowDone = slowV;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid     <= 1'b0;
      resDest      <= '0;
      collisionErr <= 1'b0;
    end else begin
      resValid     <= fastV || slowV;
      collisionErr <= fastV && slowV;
      if (fastV)      resDest <= fastDest;
      else if (slowV) resDest <= slowDest;
    end
  end

endmodule

// File: rtl/shared_alu.sv
module shared_alu
  import alu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEST_W = 6,
  parameter int ADD_LAT = 12,
  parameter int MUL_CORE_LAT = 5,
  parameter int DIV_LAT = 27
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [1:0]        issueOp,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DEST_W-1:0] issueDest,
  output logic              resValid,
  output logic [DATA_W-1:0] resData,
  output logic [DEST_W-1:0] resDest,
  output logic              collisionErr,
  output logic              divZeroErr
);

  dpStrobe_t st;

  alu_control #(.DEST_W(DEST_W), .ADD_LAT(ADD_LAT), .DIV_LAT(DIV_LAT)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .issueValid  (issueValid),
    .issueOp     (issueOp),
    .issueDest   (issueDest),
    .st          (st),
    .resValid    (resValid),
    .resDest     (resDest),
    .collisionErr(collisionErr)
  );

  alu_datapath #(
    .DATA_W(DATA_W), .ADD_LAT(ADD_LAT),
    .MUL_CORE_LAT(MUL_CORE_LAT), .DIV_LAT(DIV_LAT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .opA       (opA),
    .opB       (opB),
    .st        (st),
    .resData   (resData),
    .divZeroErr(divZeroErr)
  );

endmodule

// File: rtl/shared_alu_checker.sv
module shared_alu_checker #(
  parameter int ADD_LAT = 12,
  parameter int DIV_LAT = 27
) (
  input logic       clk,
  input logic       rstN,
  input logic       issueValid,
  input logic [1:0] issueOp,
  input logic       resValid,
  input logic       collisionErr,
  input logic       divZeroErr
);

  localparam int CNT_W = $clog2(DIV_LAT + 2) + 1;

  logic [CNT_W-1:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       sinceRst <= '0;
    else if (sinceRst < CNT_W'(DIV_LAT)) sinceRst <= sinceRst + 1'b1;
  end

  logic fastIssue, slowIssue;
  assign fastIssue = issueValid && (issueOp != 2'd3);
  assign slowIssue = issueValid && (issueOp == 2'd3);

  AST_FAST_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= CNT_W'(ADD_LAT)) && $past(fastIssue, ADD_LAT) |-> resValid); // R2

  AST_DIV_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= CNT_W'(DIV_LAT)) && $past(slowIssue, DIV_LAT) |-> resValid); // R4

  AST_COLLIDE_HAS_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    collisionErr |-> resValid); // R6

  AST_COLLIDE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= CNT_W'(DIV_LAT)) && collisionErr |->
      ($past(slowIssue, DIV_LAT) && $past(fastIssue, ADD_LAT))); // R6

  AST_DZ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    divZeroErr |=> divZeroErr); // R8

  AST_IDLE_NO_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= CNT_W'(DIV_LAT)) && !$past(issueValid, ADD_LAT)
      && !$past(issueValid, DIV_LAT) |-> !resValid); // R9

endmodule

bind shared_alu shared_alu_checker #(.ADD_LAT(ADD_LAT), .DIV_LAT(DIV_LAT)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .issueValid  (issueValid),
  .issueOp     (issueOp),
  .resValid    (resValid),
  .collisionErr(collisionErr),
  .divZeroErr  (divZeroErr)
);

// File: tb/sim_shared_alu.sv
module sim_shared_alu;

  localparam int W  = 16;
  localparam int DW = 6;
  localparam int AL = 12;
  localparam int DL = 27;
  localparam int NS = 4096;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic          rstN = 1'b0;
  logic          issueValid = 1'b0;
  logic [1:0]    issueOp = '0;
  logic [W-1:0]  opA = '0, opB = '0;
  logic [DW-1:0] issueDest = '0;
  logic          resValid, collisionErr, divZeroErr;
  logic [W-1:0]  resData;
  logic [DW-1:0] resDest;

  shared_alu #(.DATA_W(W), .DEST_W(DW), .ADD_LAT(AL), .DIV_LAT(DL)) u0 (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueOp(issueOp),
    .opA(opA), .opB(opB), .issueDest(issueDest), .resValid(resValid),
    .resData(resData), .resDest(resDest), .collisionErr(collisionErr),
    .divZeroErr(divZeroErr)
  );

  int checks = 0, errors = 0, slot = 0;
  bit dzSeen = 0;

  // expected completions, indexed by completion slot
  bit            fV [NS];
  logic [W-1:0]  fD [NS];
  logic [DW-1:0] fT [NS];
  bit            fM [NS];
  bit            sV [NS];
  logic [W-1:0]  sD [NS];
  logic [DW-1:0] sT [NS];
  bit            sZ [NS];

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s slot %0d: actual %0h expected %0h", req, what, slot, act, exp);
    end
  endtask

  function automatic logic [W-1:0] fastModel(logic [1:0] op, logic [W-1:0] a, logic [W-1:0] b);
    logic [2*W-1:0] p;
    p = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    case (op)
      2'd0:    return a + b;
      2'd1:    return a - b;
      default: return p[W-1:0];
    endcase
  endfunction

  function automatic logic [W-1:0] divModel(logic [W-1:0] a, logic [W-1:0] b);
    if (b == '0) return {W{1'b1}};
    return a / b;
  endfunction

  task automatic checkSlot();
    int i = slot;
    bit ev = fV[i] || sV[i];
    if (sV[i] && sZ[i]) dzSeen = 1;
    chk(ev ? "R5" : "R9", "resValid", 32'(resValid), 32'(ev));
    if (fV[i]) begin
      chk(fM[i] ? "R3" : "R2", "resData", 32'(resData), 32'(fD[i]));
      chk(fM[i] ? "R3" : "R2", "resDest", 32'(resDest), 32'(fT[i]));
    end else if (sV[i]) begin
      chk(sZ[i] ? "R7" : "R4", "resData", 32'(resData), 32'(sD[i]));
      chk("R4", "resDest", 32'(resDest), 32'(sT[i]));
    end
    chk("R6", "collisionErr", 32'(collisionErr), 32'(fV[i] && sV[i]));
    chk("R8", "divZeroErr", 32'(divZeroErr), 32'(dzSeen));
  endtask

  task automatic step(bit v, logic [1:0] op, logic [W-1:0] a, logic [W-1:0] b, logic [DW-1:0] d);
    @(negedge clk);
    checkSlot();
    issueValid = v; issueOp = op; opA = a; opB = b; issueDest = d;
    if (v) begin
      if (op == 2'd3) begin
        sV[slot+DL] = 1; sD[slot+DL] = divModel(a, b);
        sT[slot+DL] = d; sZ[slot+DL] = (b == '0);
      end else begin
        fV[slot+AL] = 1; fD[slot+AL] = fastModel(op, a, b);
        fT[slot+AL] = d; fM[slot+AL] = (op == 2'd2);
      end
    end
    slot++;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(0, 2'd0, '0, '0, '0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [1:0] rop;
    logic [W-1:0] ra, rb;
    repeat (3) @(negedge clk);
    chk("R1", "resValid in reset", 32'(resValid), 0);
    chk("R1", "divZeroErr in reset", 32'(divZeroErr), 0);
    rstN = 1'b1;
    chk("R1", "collisionErr after reset", 32'(collisionErr), 0);
    chk("R1", "resValid after reset", 32'(resValid), 0);

    // directed arithmetic corners
    step(1, 2'd0, 16'hFFFF, 16'h0002, 6'd1);   // R2 wrap
    step(1, 2'd1, 16'h0003, 16'h0005, 6'd2);   // R2 underflow
    step(1, 2'd2, 16'h1234, 16'h0100, 6'd3);   // R3
    step(1, 2'd2, 16'hFFFF, 16'hFFFF, 6'd4);   // R3 truncated
    step(1, 2'd3, 16'd1000, 16'd7,    6'd5);   // R4
    step(1, 2'd3, 16'd5,    16'd9,    6'd6);   // R4 zero quotient
    step(1, 2'd3, 16'hFFFF, 16'd1,    6'd7);   // R4
    step(0, 2'd0, '0, '0, '0);
    step(1, 2'd3, 16'd3, 16'd2, 6'd8);         // R5 divide issued before an add
    step(1, 2'd0, 16'd10, 16'd20, 6'd9);       // add completes first
    idle(40);

    // collision: divide then add fifteen cycles later (R6)
    step(1, 2'd3, 16'd900, 16'd30, 6'd10);
    idle(DL - AL - 1);
    step(1, 2'd0, 16'd1, 16'd1, 6'd11);
    idle(40);

    // zero-divisor divide dropped by a collision still sets the flag (R7, R8)
    step(1, 2'd3, 16'd77, 16'd0, 6'd12);
    idle(DL - AL - 1);
    step(1, 2'd2, 16'd3, 16'd4, 6'd13);
    idle(40);
    step(1, 2'd3, 16'd55, 16'd0, 6'd14);       // R7 kept result
    idle(40);

    // seeded random traffic, mostly back-to-back (R5)
    void'($urandom(32'd20240611));
    for (int n = 0; n < 1500; n++) begin
      rop = 2'($urandom % 4);
      ra  = W'($urandom);
      case ($urandom % 8)
        0:       rb = '0;
        1, 2, 3: rb = W'($urandom % 256);
        default: rb = W'($urandom);
      endcase
      step(($urandom % 5) != 0, rop, ra, rb, DW'($urandom));
    end
    idle(DL + 4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule